// File: doc/BRIEF.md
# Graphics Front-End Control Register Bank with Change Tracking

This block is the control register bank that sits in front of a graphics pipeline. A host reaches it over a simple synchronous bus that carries a byte address, write data, a write strobe and registered read data. Most words store what is written. Some are constants that cannot be written. Some are command words: writing one of them sends a single-cycle pulse to a downstream engine, and may also store a value or clear itself.

Two table regions sit beside the control words. The first is a 1024-word colour palette. Every write to the palette that changes a stored word marks it dirty and bumps two sets of revision counters. The coarse set has four counters, one for each 256 entries. The fine set has sixty-four counters, one for each 16 entries. A renderer can compare these counters to find out which part of the palette it has to reload. The second region is a 128-word fog table, which only keeps a dirty mark.

Each dirty mark is a two-state machine with the states ST_CLEAN and ST_DIRTY. The MARK transition (ST_CLEAN to ST_DIRTY) is taken on a changing write. The ACK transition (ST_DIRTY to ST_CLEAN) is taken when the consumer raises its acknowledge and no changing write happens in the same cycle. When MARK and ACK come together, the state stays at or moves to ST_DIRTY.

Top module: `gfx_regbank`

## Requirements
- R1: The bus address is ANDed with the mask 0x0000_3FFC before any decoding, so address bits 31:14 and 1:0 have no effect on which word is reached.
- R2: The words at 0x000 (value 0x17FD11DB), 0x004 (value 0x00000011) and 0x034 (value 0) are read-only. Writes to them are discarded and do not change what a read returns.
- R3: bus_rdata is registered. It shows the word at the address presented in cycle N during cycle N+1, and shows the value stored before any write made in cycle N. An address that maps to nothing reads as zero.
- R4: A write of any value to 0x010 gives a pulse_start that is high for exactly the one cycle after the write. The word at 0x010 always reads zero.
- R5: A write to 0x014 with bit 31 set gives a one-cycle pulse_list_init and stores zero. A write to 0x014 with bit 31 clear stores the data and gives no pulse.
- R6: The word at 0x008 resets to 0x00000007. Any write to it stores zero. It gives a one-cycle pulse_soft_reset only when bit 0 of the written data is 1.
- R7: Any write to 0x018 stores the data and gives a one-cycle pulse_list_cont.
- R8: Writes to 0x020, 0x024 or 0x028 store the data and give a one-cycle pulse_timing. A write to 0x030 stores the data and gives a one-cycle pulse_yuv_init.
- R9: The palette occupies 0x1000 to 0x1FFC. The entry index is address bits 11:2, and every write stores its data. Only a write whose data differs from the stored word counts as a change. A change increments the coarse counter number index>>8 (read at 0x800 + 4*n) and the fine counter number index>>4 (read at 0x900 + 4*n), each by one, modulo 2^32.
- R10: The fog table occupies 0x200 to 0x3FC and stores every write. A write whose data differs from the stored word sets fog_dirty in the next cycle. A write of equal data does not set it.
- R11: pal_dirty and fog_dirty are high in the cycle after their MARK. Each flag falls in the cycle after its ack input is high, provided no change happens in the same cycle. When a change and an ack come together, the flag is high in the next cycle.
- R12: After reset, all stored words, palette entries, fog entries and counters are zero, except for the values given in R2 and R6. Both dirty flags are low and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 32 | Registered read data |
| pal_ack | input | 1 | Consumer acknowledge for the palette dirty flag |
| fog_ack | input | 1 | Consumer acknowledge for the fog dirty flag |
| pulse_start | output | 1 | Start-render command pulse |
| pulse_list_init | output | 1 | List-initialise command pulse |
| pulse_soft_reset | output | 1 | Soft-reset command pulse |
| pulse_list_cont | output | 1 | List-continue command pulse |
| pulse_timing | output | 1 | Timing-recalculate pulse |
| pulse_yuv_init | output | 1 | YUV-setup pulse |
| pal_dirty | output | 1 | Palette has changed since the last acknowledge |
| fog_dirty | output | 1 | Fog table has changed since the last acknowledge |

## Verification
The palette path gets a long random series of writes. They are spread over all 1024 entries, and the data is drawn from only two values, so writes that repeat a stored word are about as common as writes that change it. Reading back every coarse and fine counter afterwards shows whether unchanged writes were wrongly counted, and whether the group index was taken from the wrong address bits. The same series raises the acknowledge at random, sometimes together with a changing write, which separates set-wins from ack-wins behaviour. Directed writes to each command word use data with the trigger bit set and then clear, and use addresses carrying stray high and low bits, to tell the filtering and masking rules apart.

// File: rtl/gfx_regbank_pkg.sv
package gfx_regbank_pkg;

    // control word offsets (byte addresses after masking)
    localparam logic [31:0] OFS_ID        = 32'h0000_0000;
    localparam logic [31:0] OFS_REV       = 32'h0000_0004;
    localparam logic [31:0] OFS_SRST      = 32'h0000_0008;
    localparam logic [31:0] OFS_START     = 32'h0000_0010;
    localparam logic [31:0] OFS_LINIT     = 32'h0000_0014;
    localparam logic [31:0] OFS_LCONT     = 32'h0000_0018;
    localparam logic [31:0] OFS_FBRD      = 32'h0000_0020;
    localparam logic [31:0] OFS_SYNC_CTRL = 32'h0000_0024;
    localparam logic [31:0] OFS_SYNC_LOAD = 32'h0000_0028;
    localparam logic [31:0] OFS_YUV_BASE  = 32'h0000_0030;
    localparam logic [31:0] OFS_YUV_CNT   = 32'h0000_0034;

    // region bases
    localparam logic [31:0] FOG_BASE      = 32'h0000_0200;
    localparam logic [31:0] CNT_HI_BASE   = 32'h0000_0800;
    localparam logic [31:0] CNT_LO_BASE   = 32'h0000_0900;
    localparam logic [31:0] PAL_BASE      = 32'h0000_1000;

    // fixed values
    localparam logic [31:0] ID_VAL        = 32'h17FD_11DB;
    localparam logic [31:0] REV_VAL       = 32'h0000_0011;
    localparam logic [31:0] SRST_VAL      = 32'h0000_0007;

    typedef enum logic {
        ST_CLEAN = 1'b0,
        ST_DIRTY = 1'b1
    } dirty_state_t;

    typedef struct packed {
        logic start;
        logic list_init;
        logic soft_reset;
        logic list_cont;
        logic timing;
        logic yuv_init;
    } trig_t;

endpackage

// File: rtl/gfx_dirty_fsm.sv
module gfx_dirty_fsm
    import gfx_regbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mark,
    input  logic ack,
    output logic dirty
);

    dirty_state_t state_q;
    dirty_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: MARK takes precedence over ACK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN: begin
                if (mark) begin
                    state_d = ST_DIRTY;
                end
            end
            ST_DIRTY: begin
                if (ack && !mark) begin
                    state_d = ST_CLEAN;
                end
            end
            default: state_d = ST_CLEAN;
        endcase
    end

    // outputs
    always_comb begin
        dirty = (state_q == ST_DIRTY);
    end

endmodule

// File: rtl/gfx_ctrl_regs.sv
module gfx_ctrl_regs
    import gfx_regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    output trig_t       trig_q,
    output logic [31:0] rd_data
);

    logic [31:0] srst_q;
    logic [31:0] linit_q;
    logic [31:0] lcont_q;
    logic [31:0] fbrd_q;
    logic [31:0] sctl_q;
    logic [31:0] sload_q;
    logic [31:0] ybase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srst_q  <= SRST_VAL;
            linit_q <= '0;
            lcont_q <= '0;
            fbrd_q  <= '0;
            sctl_q  <= '0;
            sload_q <= '0;
            ybase_q <= '0;
            trig_q  <= '0;
        end else begin
            trig_q <= '0;
            if (wr) begin
                case (addr)
                    OFS_SRST: begin
                        srst_q            <= '0;
                        trig_q.soft_reset <= wdata[0];
                    end
                    OFS_START: begin
                        trig_q.start <= 1'b1;
                    end
                    OFS_LINIT: begin
                        if (wdata[31]) begin
                            linit_q          <= '0;
                            trig_q.list_init <= 1'b1;
                        end else begin
                            linit_q <= wdata;
                        end
                    end
                    OFS_LCONT: begin
                        lcont_q          <= wdata;
                        trig_q.list_cont <= 1'b1;
                    end
                    OFS_FBRD: begin
                        fbrd_q        <= wdata;
                        trig_q.timing <= 1'b1;
                    end
                    OFS_SYNC_CTRL: begin
                        sctl_q        <= wdata;
                        trig_q.timing <= 1'b1;
                    end
                    OFS_SYNC_LOAD: begin
                        sload_q       <= wdata;
                        trig_q.timing <= 1'b1;
                    end
                    OFS_YUV_BASE: begin
                        ybase_q         <= wdata;
                        trig_q.yuv_init <= 1'b1;
                    end
                    default: ; // read-only or unmapped: discarded
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            OFS_ID:        rd_data = ID_VAL;
            OFS_REV:       rd_data = REV_VAL;
            OFS_SRST:      rd_data = srst_q;
            OFS_LINIT:     rd_data = linit_q;
            OFS_LCONT:     rd_data = lcont_q;
            OFS_FBRD:      rd_data = fbrd_q;
            OFS_SYNC_CTRL: rd_data = sctl_q;
            OFS_SYNC_LOAD: rd_data = sload_q;
            OFS_YUV_BASE:  rd_data = ybase_q;
            default:       rd_data = '0; // includes start and YUV count
        endcase
    end

endmodule

// File: rtl/gfx_table_bank.sv
module gfx_table_bank #(
    parameter int unsigned WORDS  = 1024,
    parameter int unsigned GRP_HI = 256,
    parameter int unsigned GRP_LO = 16,
    parameter int unsigned CNT_W  = 32,
    parameter bit          TRACK  = 1'b1,
    localparam int unsigned IDX_W  = $clog2(WORDS),
    localparam int unsigned NUM_HI = WORDS / GRP_HI,
    localparam int unsigned NUM_LO = WORDS / GRP_LO,
    localparam int unsigned HI_W   = $clog2(NUM_HI),
    localparam int unsigned LO_W   = $clog2(NUM_LO)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic             change,
    output logic [31:0]      rd_word,
    input  logic [HI_W-1:0]  hi_sel,
    input  logic [LO_W-1:0]  lo_sel,
    output logic [CNT_W-1:0] hi_val,
    output logic [CNT_W-1:0] lo_val
);

    localparam int unsigned HI_SH = $clog2(GRP_HI);
    localparam int unsigned LO_SH = $clog2(GRP_LO);

    logic [31:0] mem_q [WORDS];

    always_comb begin
        change  = wr_en && (mem_q[idx] != wdata);
        rd_word = mem_q[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(WORDS); i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[idx] <= wdata;
        end
    end

    generate
        if (TRACK) begin : g_track
            logic [CNT_W-1:0] hi_q [NUM_HI];
            logic [CNT_W-1:0] lo_q [NUM_LO];
            logic [HI_W-1:0]  hi_grp;
            logic [LO_W-1:0]  lo_grp;

            assign hi_grp = idx[IDX_W-1:HI_SH];
            assign lo_grp = idx[IDX_W-1:LO_SH];

            for (genvar g = 0; g < int'(NUM_HI); g++) begin : g_hi
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        hi_q[g] <= '0;
                    end else if (change && (hi_grp == HI_W'(g))) begin
                        hi_q[g] <= hi_q[g] + 1'b1;
                    end
                end
            end

            for (genvar g = 0; g < int'(NUM_LO); g++) begin : g_lo
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        lo_q[g] <= '0;
                    end else if (change && (lo_grp == LO_W'(g))) begin
                        lo_q[g] <= lo_q[g] + 1'b1;
                    end
                end
            end

            assign hi_val = hi_q[hi_sel];
            assign lo_val = lo_q[lo_sel];
        end else begin : g_plain
            assign hi_val = (hi_sel == '0 && lo_sel == '0) ? '0 : '0;
            assign lo_val = '0;
        end
    endgenerate

endmodule

// File: rtl/gfx_regbank.sv
module gfx_regbank
    import gfx_regbank_pkg::*;
#(
    parameter logic [31:0] ADDR_MASK  = 32'h0000_3FFC,
    parameter int unsigned PAL_WORDS  = 1024,
    parameter int unsigned PAL_GRP_HI = 256,
    parameter int unsigned PAL_GRP_LO = 16,
    parameter int unsigned FOG_WORDS  = 128,
    parameter int unsigned CNT_W      = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_wr,
    output logic [31:0] bus_rdata,
    input  logic        pal_ack,
    input  logic        fog_ack,
    output logic        pulse_start,
    output logic        pulse_list_init,
    output logic        pulse_soft_reset,
    output logic        pulse_list_cont,
    output logic        pulse_timing,
    output logic        pulse_yuv_init,
    output logic        pal_dirty,
    output logic        fog_dirty
);

    localparam int unsigned PAL_IDX_W = $clog2(PAL_WORDS);
    localparam int unsigned FOG_IDX_W = $clog2(FOG_WORDS);
    localparam int unsigned NUM_HI    = PAL_WORDS / PAL_GRP_HI;
    localparam int unsigned NUM_LO    = PAL_WORDS / PAL_GRP_LO;
    localparam int unsigned HI_W      = $clog2(NUM_HI);
    localparam int unsigned LO_W      = $clog2(NUM_LO);
    localparam logic [31:0] PAL_END    = PAL_BASE + 32'(PAL_WORDS * 4);
    localparam logic [31:0] FOG_END    = FOG_BASE + 32'(FOG_WORDS * 4);
    localparam logic [31:0] CNT_HI_END = CNT_HI_BASE + 32'(NUM_HI * 4);
    localparam logic [31:0] CNT_LO_END = CNT_LO_BASE + 32'(NUM_LO * 4);

    logic [31:0] masked;
    logic        in_pal, in_fog, in_hi, in_lo;
    logic        pal_mark, fog_mark;
    logic [31:0] ctrl_rd, pal_rd, fog_rd;
    logic [CNT_W-1:0] hi_val, lo_val, fog_hi_unused, fog_lo_unused;
    logic [PAL_IDX_W-1:0] pal_idx;
    logic [FOG_IDX_W-1:0] fog_idx;
    logic [HI_W-1:0] hi_sel;
    logic [LO_W-1:0] lo_sel;
    logic [31:0] rd_next;
    trig_t       trig;

    // address decode
    always_comb begin
        masked  = bus_addr & ADDR_MASK;
        in_pal  = (masked >= PAL_BASE)    && (masked < PAL_END);
        in_fog  = (masked >= FOG_BASE)    && (masked < FOG_END);
        in_hi   = (masked >= CNT_HI_BASE) && (masked < CNT_HI_END);
        in_lo   = (masked >= CNT_LO_BASE) && (masked < CNT_LO_END);
        pal_idx = PAL_IDX_W'((masked - PAL_BASE) >> 2);
        fog_idx = FOG_IDX_W'((masked - FOG_BASE) >> 2);
        hi_sel  = HI_W'((masked - CNT_HI_BASE) >> 2);
        lo_sel  = LO_W'((masked - CNT_LO_BASE) >> 2);
    end

    gfx_ctrl_regs u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (masked),
        .wdata   (bus_wdata),
        .trig_q  (trig),
        .rd_data (ctrl_rd)
    );

    gfx_table_bank #(
        .WORDS  (PAL_WORDS),
        .GRP_HI (PAL_GRP_HI),
        .GRP_LO (PAL_GRP_LO),
        .CNT_W  (CNT_W),
        .TRACK  (1'b1)
    ) u_pal (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr && in_pal),
        .idx     (pal_idx),
        .wdata   (bus_wdata),
        .change  (pal_mark),
        .rd_word (pal_rd),
        .hi_sel  (hi_sel),
        .lo_sel  (lo_sel),
        .hi_val  (hi_val),
        .lo_val  (lo_val)
    );

    gfx_table_bank #(
        .WORDS  (FOG_WORDS),
        .GRP_HI (FOG_WORDS),
        .GRP_LO (FOG_WORDS / 2),
        .CNT_W  (CNT_W),
        .TRACK  (1'b0)
    ) u_fog (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr && in_fog),
        .idx     (fog_idx),
        .wdata   (bus_wdata),
        .change  (fog_mark),
        .rd_word (fog_rd),
        .hi_sel  (1'b0),
        .lo_sel  (1'b0),
        .hi_val  (fog_hi_unused),
        .lo_val  (fog_lo_unused)
    );

    gfx_dirty_fsm u_pal_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .mark  (pal_mark),
        .ack   (pal_ack),
        .dirty (pal_dirty)
    );

    gfx_dirty_fsm u_fog_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .mark  (fog_mark),
        .ack   (fog_ack),
        .dirty (fog_dirty)
    );

    // read mux, registered
    always_comb begin
        if (in_pal) begin
            rd_next = pal_rd;
        end else if (in_fog) begin
            rd_next = fog_rd;
        end else if (in_hi) begin
            rd_next = 32'(hi_val);
        end else if (in_lo) begin
            rd_next = 32'(lo_val);
        end else begin
            rd_next = ctrl_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_next;
        end
    end

    always_comb begin
        pulse_start      = trig.start;
        pulse_list_init  = trig.list_init;
        pulse_soft_reset = trig.soft_reset;
        pulse_list_cont  = trig.list_cont;
        pulse_timing     = trig.timing;
        pulse_yuv_init   = trig.yuv_init;
    end

endmodule

// File: rtl/gfx_regbank_chk.sv
module gfx_regbank_chk
    import gfx_regbank_pkg::*;
#(
    parameter logic [31:0] ADDR_MASK = 32'h0000_3FFC
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_wr,
    input logic [31:0] bus_rdata,
    input logic        pal_ack,
    input logic        fog_ack,
    input logic        pal_mark,
    input logic        fog_mark,
    input logic        pal_dirty,
    input logic        fog_dirty,
    input logic        pulse_start,
    input logic        pulse_soft_reset,
    input logic        pulse_list_init,
    input logic        pulse_list_cont,
    input logic        pulse_timing,
    input logic        pulse_yuv_init
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        pulse_start |-> ($past(bus_wr) && (($past(bus_addr) & ADDR_MASK) == OFS_START))); // R4

    AST_ID_READ_CONST: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (($past(bus_addr) & ADDR_MASK) == OFS_ID) |-> (bus_rdata == ID_VAL)); // R2

    AST_SRST_NEEDS_BIT0: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        pulse_soft_reset |-> ($past(bus_wr) && $past(bus_wdata[0]))); // R6

    AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(bus_wr) |-> !(pulse_list_init || pulse_list_cont || pulse_timing || pulse_yuv_init)); // R8

    AST_PAL_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        pal_mark |=> pal_dirty); // R11

    AST_PAL_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pal_ack && !pal_mark) |=> !pal_dirty); // R11

    AST_FOG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fog_mark |=> fog_dirty); // R10

    AST_FOG_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (fog_ack && !fog_mark) |=> !fog_dirty); // R11

endmodule

bind gfx_regbank gfx_regbank_chk #(.ADDR_MASK(ADDR_MASK)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_addr         (bus_addr),
    .bus_wdata        (bus_wdata),
    .bus_wr           (bus_wr),
    .bus_rdata        (bus_rdata),
    .pal_ack          (pal_ack),
    .fog_ack          (fog_ack),
    .pal_mark         (pal_mark),
    .fog_mark         (fog_mark),
    .pal_dirty        (pal_dirty),
    .fog_dirty        (fog_dirty),
    .pulse_start      (pulse_start),
    .pulse_soft_reset (pulse_soft_reset),
    .pulse_list_init  (pulse_list_init),
    .pulse_list_cont  (pulse_list_cont),
    .pulse_timing     (pulse_timing),
    .pulse_yuv_init   (pulse_yuv_init)
);

// File: tb/tb_gfx_regbank.sv
`timescale 1ns/1ps
module tb_gfx_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_rdata;
    logic        pal_ack = 1'b0;
    logic        fog_ack = 1'b0;
    logic        pulse_start, pulse_list_init, pulse_soft_reset;
    logic        pulse_list_cont, pulse_timing, pulse_yuv_init;
    logic        pal_dirty, fog_dirty;

    always #2 clk = ~clk; // 250 MHz

    gfx_regbank dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .bus_addr         (bus_addr),
        .bus_wdata        (bus_wdata),
        .bus_wr           (bus_wr),
        .bus_rdata        (bus_rdata),
        .pal_ack          (pal_ack),
        .fog_ack          (fog_ack),
        .pulse_start      (pulse_start),
        .pulse_list_init  (pulse_list_init),
        .pulse_soft_reset (pulse_soft_reset),
        .pulse_list_cont  (pulse_list_cont),
        .pulse_timing     (pulse_timing),
        .pulse_yuv_init   (pulse_yuv_init),
        .pal_dirty        (pal_dirty),
        .fog_dirty        (fog_dirty)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [5:0]  trig_s;   // {start, list_init, soft_reset, list_cont, timing, yuv_init}
    logic [31:0] got;
    logic [31:0] pal_m [1024];
    logic [31:0] fog_m [128];
    logic [31:0] hi_m  [4];
    logic [31:0] lo_m  [64];
    logic        pal_dirty_m = 1'b0;
    logic        fog_dirty_m = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] pulses_now();
        return {pulse_start, pulse_list_init, pulse_soft_reset,
                pulse_list_cont, pulse_timing, pulse_yuv_init};
    endfunction

    task automatic wr(input logic [31:0] a, input logic [31:0] d,
                      input logic pa, input logic fa);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; pal_ack = pa; fog_ack = fa;
        @(negedge clk);
        bus_wr = 1'b0; pal_ack = 1'b0; fog_ack = 1'b0;
        trig_s = pulses_now();
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic ack_only(input logic pa, input logic fa);
        @(negedge clk);
        pal_ack = pa; fog_ack = fa; bus_wr = 1'b0;
        @(negedge clk);
        pal_ack = 1'b0; fog_ack = 1'b0;
    endtask

    // palette write through the model, then on the design
    task automatic pal_write(input int idx, input logic [31:0] d, input logic ack);
        logic changed;
        changed = (pal_m[idx] != d);
        pal_m[idx] = d;
        if (changed) begin
            hi_m[idx >> 8] = hi_m[idx >> 8] + 1;
            lo_m[idx >> 4] = lo_m[idx >> 4] + 1;
            pal_dirty_m = 1'b1;
        end else if (ack) begin
            pal_dirty_m = 1'b0;
        end
        wr(32'h1000 + 32'(idx * 4), d, ack, 1'b0);
    endtask

    task automatic fog_write(input int idx, input logic [31:0] d, input logic ack);
        if (fog_m[idx] != d) fog_dirty_m = 1'b1;
        else if (ack) fog_dirty_m = 1'b0;
        fog_m[idx] = d;
        wr(32'h0200 + 32'(idx * 4), d, 1'b0, ack);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240613));
        for (int i = 0; i < 1024; i++) pal_m[i] = '0;
        for (int i = 0; i < 128; i++) fog_m[i] = '0;
        for (int i = 0; i < 4; i++) hi_m[i] = '0;
        for (int i = 0; i < 64; i++) lo_m[i] = '0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        check("R12 pulses after reset", 32'(pulses_now()), 32'd0);
        check("R12 pal_dirty after reset", 32'(pal_dirty), 32'd0);
        check("R12 fog_dirty after reset", 32'(fog_dirty), 32'd0);
        rd(32'h008, got); check("R12 R6 soft-reset word reset value", got, 32'h7);
        rd(32'h0800, got); check("R12 coarse counter 0", got, 32'd0);
        rd(32'h1000 + 32'd40, got); check("R12 palette word", got, 32'd0);
        rd(32'h020, got); check("R12 timing word", got, 32'd0);

        // R2: read-only words
        wr(32'h000, 32'hFFFF_FFFF, 1'b0, 1'b0);
        check("R2 no pulse on ID write", 32'(trig_s), 32'd0);
        rd(32'h000, got); check("R2 ID unchanged", got, 32'h17FD_11DB);
        wr(32'h004, 32'h0, 1'b0, 1'b0);
        rd(32'h004, got); check("R2 revision unchanged", got, 32'h11);
        wr(32'h034, 32'h1234_5678, 1'b0, 1'b0);
        rd(32'h034, got); check("R2 YUV count unchanged", got, 32'h0);

        // R3: unmapped reads zero, read before write ordering
        rd(32'h0FC, got); check("R3 unmapped read", got, 32'h0);
        @(negedge clk);
        bus_addr = 32'h020; bus_wdata = 32'hCAFE_0001; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R3 read shows old word during write", bus_rdata, 32'h0);
        @(negedge clk);
        check("R3 read shows new word next cycle", bus_rdata, 32'hCAFE_0001);

        // R1: masking of stray address bits, R5 no pulse with bit31 clear
        wr(32'hFFFF_C016, 32'h0000_0005, 1'b0, 1'b0);
        check("R1 R5 no list-init pulse without bit31", 32'(trig_s), 32'd0);
        rd(32'h0000_0014, got); check("R1 masked write landed", got, 32'h5);
        rd(32'hABCD_4017, got); check("R1 masked read", got, 32'h5);

        // R4: start trigger
        wr(32'h010, 32'h1234, 1'b0, 1'b0);
        check("R4 start pulse", 32'(trig_s), 32'b100000);
        @(negedge clk);
        check("R4 start pulse one cycle", 32'(pulse_start), 32'd0);
        rd(32'h010, got); check("R4 start word reads zero", got, 32'h0);

        // R5: list-init with bit31
        wr(32'h014, 32'h8000_0001, 1'b0, 1'b0);
        check("R5 list-init pulse", 32'(trig_s), 32'b010000);
        rd(32'h014, got); check("R5 list-init self-clears", got, 32'h0);

        // R6: soft reset
        wr(32'h008, 32'h6, 1'b0, 1'b0);
        check("R6 no pulse with bit0 clear", 32'(trig_s), 32'd0);
        rd(32'h008, got); check("R6 nonzero write stores zero", got, 32'h0);
        wr(32'h008, 32'h3, 1'b0, 1'b0);
        check("R6 pulse with bit0 set", 32'(trig_s), 32'b001000);
        wr(32'h008, 32'h0, 1'b0, 1'b0);
        check("R6 zero write no pulse", 32'(trig_s), 32'd0);

        // R7: list continue
        wr(32'h018, 32'h55, 1'b0, 1'b0);
        check("R7 continue pulse", 32'(trig_s), 32'b000100);
        rd(32'h018, got); check("R7 continue stores data", got, 32'h55);

        // R8: timing and YUV
        wr(32'h024, 32'hA1, 1'b0, 1'b0);
        check("R8 sync-control timing pulse", 32'(trig_s), 32'b000010);
        wr(32'h028, 32'hA2, 1'b0, 1'b0);
        check("R8 sync-load timing pulse", 32'(trig_s), 32'b000010);
        rd(32'h028, got); check("R8 sync-load stored", got, 32'hA2);
        wr(32'h030, 32'hB0, 1'b0, 1'b0);
        check("R8 YUV base pulse", 32'(trig_s), 32'b000001);
        rd(32'h030, got); check("R8 YUV base stored", got, 32'hB0);

        // R9 / R11: directed palette
        pal_write(300, 32'hDEAD, 1'b0);
        check("R9 R11 change sets pal_dirty", 32'(pal_dirty), 32'd1);
        rd(32'h0804, got); check("R9 coarse counter 1", got, 32'd1);
        rd(32'h0900 + 32'd72, got); check("R9 fine counter 18", got, 32'd1);
        ack_only(1'b1, 1'b0); pal_dirty_m = 1'b0;
        check("R11 ack clears pal_dirty", 32'(pal_dirty), 32'd0);
        pal_write(300, 32'hDEAD, 1'b0);
        check("R9 equal write no dirty", 32'(pal_dirty), 32'd0);
        rd(32'h0804, got); check("R9 equal write no bump", got, 32'd1);
        rd(32'h14B0, got); check("R9 palette word stored", got, 32'hDEAD);
        pal_write(301, 32'h1, 1'b1);
        check("R11 set wins over ack", 32'(pal_dirty), 32'd1);

        // R10: fog
        fog_write(2, 32'h7, 1'b0);
        check("R10 fog change sets dirty", 32'(fog_dirty), 32'd1);
        ack_only(1'b0, 1'b1); fog_dirty_m = 1'b0;
        check("R11 fog ack clears", 32'(fog_dirty), 32'd0);
        fog_write(2, 32'h7, 1'b0);
        check("R10 fog equal write no dirty", 32'(fog_dirty), 32'd0);
        rd(32'h0208, got); check("R10 fog word stored", got, 32'h7);

        // R9 / R11: random palette traffic
        for (int n = 0; n < 600; n++) begin
            int idx;
            logic [31:0] d;
            logic a;
            idx = int'($urandom % 1024);
            d   = 32'($urandom % 2);
            a   = (($urandom % 4) == 0);
            pal_write(idx, d, a);
            check("R11 random pal_dirty", 32'(pal_dirty), 32'(pal_dirty_m));
        end
        for (int k = 0; k < 4; k++) begin
            rd(32'h0800 + 32'(k * 4), got); check("R9 random coarse counter", got, hi_m[k]);
        end
        for (int k = 0; k < 64; k++) begin
            rd(32'h0900 + 32'(k * 4), got); check("R9 random fine counter", got, lo_m[k]);
        end
        for (int k = 0; k < 16; k++) begin
            int idx;
            idx = int'($urandom % 1024);
            rd(32'h1000 + 32'(idx * 4), got); check("R9 random palette word", got, pal_m[idx]);
        end

        // R10: random fog traffic
        for (int n = 0; n < 100; n++) begin
            int idx;
            logic [31:0] d;
            logic a;
            idx = int'($urandom % 128);
            d   = 32'($urandom % 2);
            a   = (($urandom % 3) == 0);
            fog_write(idx, d, a);
            check("R10 random fog_dirty", 32'(fog_dirty), 32'(fog_dirty_m));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule